// File: doc/BRIEF.md
# Sensor Pixel Region Tagger

This block sits behind the readout sequencer of a full-frame CCD front end. For every digitized sample it receives a 1-based line index, a 1-based column index, a valid strobe and an unsigned data word. In the same cycle it returns a 3-bit region code that names the physical region the sample came from. It also raises a strobe for usable image pixels and a flag for samples that are real shielded dark pixels.

The column map is fixed and has 3448 positions per line. In readout order it holds the leading dummy columns, a photoactive test column, dark-dummy columns, buffer columns, the image area and the trailing dark-reference band, then the trailing dummies. The line map has 2574 lines, made up of dark-dummy bands, twelve fully shielded lines at the start of the frame, buffer bands and the image lines. The region of a sample comes from combining the two maps.

Each line's 39 trailing dark-reference samples are summed. The sum is divided by 39 with a reciprocal multiply, and the result is registered as that line's dark level. Dummy, virtual-dummy and dark-dummy samples never enter the average. A parameter selects a monochrome sensor: in that variant the blue-filtered buffer becomes active buffer.

Top module: `pixreg_tagger`

## Requirements
- R1: On an image line (47 to 2550), 1-based columns decode as follows: 1-4 virtual dummy, 5-12 dummy, 13 test, 14-18 dummy, 19-23 dark dummy, 24-27 blue buffer, 28-43 active buffer, 44-3369 active, 3370-3385 active buffer, 3386-3389 blue buffer, 3390-3397 dark dummy, 3398-3436 dark reference, 3437-3442 dark dummy, 3443-3445 dummy, 3446 test, 3447-3448 dummy.
- R2: `region` is combinational from the current inputs and uses these codes: 0 virtual dummy, 1 dummy, 2 test monitor, 3 dark dummy, 4 blue buffer, 5 active buffer, 6 active, 7 dark reference.
- R3: On lines 1-6, 19-26 and 2571-2574, the buffer, active and dark-reference columns decode as dark dummy (3). Dummy, virtual-dummy and test columns keep their column code.
- R4: On lines 7-18, the buffer and active columns decode as dark reference (7). Dark-dummy columns stay dark dummy.
- R5: On lines 27-30 and 2551-2554, the buffer and active columns decode as blue buffer (4). On lines 31-46 and 2555-2570, the active and active-buffer columns decode as active buffer (5) and the blue columns stay blue (4). The dark-reference columns stay 7 on all of these lines.
- R6: Column 13 decodes as test monitor (2) on lines 1-1411 and as dark dummy (3) from line 1412. Column 3446 is always test monitor.
- R7: `act_stb` is high exactly when `pix_vld` is high and `region` is 6.
- R8: `dark_ok` is high exactly when `pix_vld` is high and `region` is 7.
- R9: When a valid sample at column 3436 has region 7, then one cycle later `dark_upd` pulses for one cycle. At the same time `dark_level` becomes floor(S/39), where S is the sum of the valid region-7 samples of columns 3398-3436 on that line. A valid sample at column 3398 restarts the sum.
- R10: `dark_level` resets to 0 and changes only on a `dark_upd` cycle. `dark_upd` resets to 0.
- R11: With MONO=1, every sample that would decode as blue buffer (4) decodes as active buffer (5) instead.
- R12: Line 0, lines above 2574, column 0 and columns above 3448 decode as dummy (1).
- R13: Samples with `pix_vld` low do not enter the dark sum and do not raise `act_stb` or `dark_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | Sample valid strobe |
| line_idx | input | IDX_W | 1-based line index |
| col_idx | input | IDX_W | 1-based column index |
| pix_data | input | DATA_W | Unsigned digitized sample |
| region | output | 3 | Region code of the current sample |
| dark_ok | output | 1 | Valid dark-reference sample |
| act_stb | output | 1 | Valid active image sample |
| dark_level | output | DATA_W | Registered per-line dark level |
| dark_upd | output | 1 | One-cycle pulse when dark_level is loaded |

## Verification
The bench builds two instances side by side with the full-size defaults (3326 active columns, 39 dark columns, 2504 image lines), one with MONO=0 and one with MONO=1. The full-size map lets the bench reach every column and line boundary, including the test column switching at line 1411/1412. Running MONO=1 alongside MONO=0 on the same stream exposes the blue-to-active-buffer remap. With 12-bit data, an all-4095 line drives the reciprocal divider to its largest sum, and a line whose only non-zero dark sample is 38 probes the floor just below one.

// File: rtl/pixreg_pkg.sv
package pixreg_pkg;

    typedef enum logic [2:0] {
        RG_VDUM = 3'd0,
        RG_DUM  = 3'd1,
        RG_CTE  = 3'd2,
        RG_DDUM = 3'd3,
        RG_BLUE = 3'd4,
        RG_ABUF = 3'd5,
        RG_ACT  = 3'd6,
        RG_DREF = 3'd7
    } region_e;

    typedef enum logic [2:0] {
        LC_DDUM = 3'd0,
        LC_DARK = 3'd1,
        LC_BLUE = 3'd2,
        LC_ABUF = 3'd3,
        LC_ACT  = 3'd4,
        LC_NONE = 3'd5
    } line_cls_e;

    localparam int COL_SEGS     = 16;
    localparam int LINE_SEGS    = 9;
    localparam int LEAD_CTE_SEG = 2;
    localparam int DREF_SEG     = 11;

    // region carried by each column segment, in readout order
    localparam region_e COL_SEG_REG [COL_SEGS] = '{
        RG_VDUM, RG_DUM, RG_CTE, RG_DUM, RG_DDUM, RG_BLUE, RG_ABUF, RG_ACT,
        RG_ABUF, RG_BLUE, RG_DDUM, RG_DREF, RG_DDUM, RG_DUM, RG_CTE, RG_DUM
    };

    // class of each line band, in readout order
    localparam line_cls_e LINE_SEG_CLS [LINE_SEGS] = '{
        LC_DDUM, LC_DARK, LC_DDUM, LC_BLUE, LC_ABUF, LC_ACT, LC_BLUE, LC_ABUF, LC_DDUM
    };

endpackage

// File: rtl/pixreg_col_decode.sv
module pixreg_col_decode
    import pixreg_pkg::*;
#(
    parameter int IDX_W       = 12,
    parameter int LEAD_VD     = 4,
    parameter int LEAD_DUM_A  = 8,
    parameter int LEAD_DUM_B  = 5,
    parameter int LEAD_DD     = 5,
    parameter int BLUE_COLS   = 4,
    parameter int ABUF_COLS   = 16,
    parameter int ACTIVE_COLS = 3326,
    parameter int TRAIL_DD_A  = 8,
    parameter int DARK_COLS   = 39,
    parameter int TRAIL_DD_B  = 6,
    parameter int TRAIL_DUM_A = 3,
    parameter int TRAIL_DUM_B = 2
) (
    input  logic [IDX_W-1:0] col_idx,
    output region_e          col_cls,
    output logic             col_in,
    output logic             lead_cte,
    output logic             dref_span,
    output logic             dref_first,
    output logic             dref_last
);

    localparam int unsigned SEG_LEN [COL_SEGS] = '{
        LEAD_VD, LEAD_DUM_A, 1, LEAD_DUM_B, LEAD_DD, BLUE_COLS, ABUF_COLS, ACTIVE_COLS,
        ABUF_COLS, BLUE_COLS, TRAIL_DD_A, DARK_COLS, TRAIL_DD_B, TRAIL_DUM_A, 1, TRAIL_DUM_B
    };

    logic [31:0] col_w;
    assign col_w = 32'(col_idx);

    always_comb begin
        int unsigned hi;
        int unsigned lo;
        hi         = 0;
        col_cls    = RG_DUM;
        col_in     = 1'b0;
        lead_cte   = 1'b0;
        dref_span  = 1'b0;
        dref_first = 1'b0;
        dref_last  = 1'b0;
        for (int s = 0; s < COL_SEGS; s++) begin
            lo = hi + 1;
            hi = hi + SEG_LEN[s];
            if (!col_in && col_w >= lo && col_w <= hi) begin
                col_in  = 1'b1;
                col_cls = COL_SEG_REG[s];
                if (s == LEAD_CTE_SEG) lead_cte = 1'b1;
                if (s == DREF_SEG) begin
                    dref_span  = 1'b1;
                    dref_first = (col_w == lo);
                    dref_last  = (col_w == hi);
                end
            end
        end
    end

endmodule

// File: rtl/pixreg_line_decode.sv
module pixreg_line_decode
    import pixreg_pkg::*;
#(
    parameter int IDX_W          = 12,
    parameter int LEAD_DD_LINES  = 6,
    parameter int DARK_LINES     = 12,
    parameter int MID_DD_LINES   = 8,
    parameter int BLUE_LINES     = 4,
    parameter int ABUF_LINES     = 16,
    parameter int ACTIVE_LINES   = 2504,
    parameter int TRAIL_DD_LINES = 4,
    parameter int CTE_LAST_LINE  = 1411
) (
    input  logic [IDX_W-1:0] line_idx,
    output line_cls_e        line_cls,
    output logic             cte_dark
);

    localparam int unsigned SEG_LEN [LINE_SEGS] = '{
        LEAD_DD_LINES, DARK_LINES, MID_DD_LINES, BLUE_LINES, ABUF_LINES,
        ACTIVE_LINES, BLUE_LINES, ABUF_LINES, TRAIL_DD_LINES
    };

    logic [31:0] line_w;
    assign line_w = 32'(line_idx);
    assign cte_dark = (line_w > CTE_LAST_LINE);

    always_comb begin
        int unsigned hi;
        int unsigned lo;
        logic        hit;
        hi       = 0;
        hit      = 1'b0;
        line_cls = LC_NONE;
        for (int s = 0; s < LINE_SEGS; s++) begin
            lo = hi + 1;
            hi = hi + SEG_LEN[s];
            if (!hit && line_w >= lo && line_w <= hi) begin
                hit      = 1'b1;
                line_cls = LINE_SEG_CLS[s];
            end
        end
    end

endmodule

// File: rtl/pixreg_dark_avg.sv
module pixreg_dark_avg #(
    parameter int DATA_W    = 12,
    parameter int DARK_COLS = 39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic              smp_first,
    input  logic              smp_last,
    input  logic [DATA_W-1:0] smp_data,
    output logic [DATA_W-1:0] dark_level,
    output logic              dark_upd
);

    localparam int SUM_W  = DATA_W + $clog2(DARK_COLS + 1);
    localparam int RSH    = SUM_W + $clog2(DARK_COLS);
    localparam int PROD_W = SUM_W + RSH + 1;
    localparam longint unsigned RECIP = ((64'd1 << RSH) + DARK_COLS - 1) / DARK_COLS;

    typedef struct packed {
        logic [SUM_W-1:0]  sum;
        logic [DATA_W-1:0] level;
        logic              upd;
    } avg_t;

    avg_t st_d, st_q;
    logic [SUM_W-1:0]  acc;
    logic [PROD_W-1:0] prod;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        acc      = (smp_first ? '0 : st_q.sum) + SUM_W'(smp_data);
        prod     = PROD_W'(acc) * PROD_W'(RECIP);
        if (smp_en) begin
            st_d.sum = acc;
            if (smp_last) begin
                st_d.level = DATA_W'(prod >> RSH);
                st_d.upd   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dark_level = st_q.level;
    assign dark_upd   = st_q.upd;

    // R9: the loaded level is the exact floor quotient of the line sum
    a_r9_exact_quotient: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd |-> ((32'(st_q.level) * DARK_COLS <= 32'(st_q.sum)) &&
                      (32'(st_q.sum) - 32'(st_q.level) * DARK_COLS < DARK_COLS)));

    // R10: the level moves only together with an update pulse
    a_r10_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.upd |-> $stable(st_q.level));

endmodule

// File: rtl/pixreg_tagger.sv
module pixreg_tagger
    import pixreg_pkg::*;
#(
    parameter int DATA_W        = 12,
    parameter int IDX_W         = 12,
    parameter int MONO          = 0,
    parameter int ACTIVE_COLS   = 3326,
    parameter int DARK_COLS     = 39,
    parameter int ACTIVE_LINES  = 2504,
    parameter int DARK_LINES    = 12,
    parameter int CTE_LAST_LINE = 1411
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_vld,
    input  logic [IDX_W-1:0]  line_idx,
    input  logic [IDX_W-1:0]  col_idx,
    input  logic [DATA_W-1:0] pix_data,
    output logic [2:0]        region,
    output logic              dark_ok,
    output logic              act_stb,
    output logic [DATA_W-1:0] dark_level,
    output logic              dark_upd
);

    region_e   ccls;
    line_cls_e lcls;
    region_e   reg_c;
    logic      col_in, lead_cte, dref_span, dref_first, dref_last, cte_dark;

    pixreg_col_decode #(
        .IDX_W       (IDX_W),
        .ACTIVE_COLS (ACTIVE_COLS),
        .DARK_COLS   (DARK_COLS)
    ) i_col (
        .col_idx    (col_idx),
        .col_cls    (ccls),
        .col_in     (col_in),
        .lead_cte   (lead_cte),
        .dref_span  (dref_span),
        .dref_first (dref_first),
        .dref_last  (dref_last)
    );

    pixreg_line_decode #(
        .IDX_W         (IDX_W),
        .DARK_LINES    (DARK_LINES),
        .ACTIVE_LINES  (ACTIVE_LINES),
        .CTE_LAST_LINE (CTE_LAST_LINE)
    ) i_line (
        .line_idx (line_idx),
        .line_cls (lcls),
        .cte_dark (cte_dark)
    );

    always_comb begin
        reg_c = RG_DUM;
        if (col_in && lcls != LC_NONE) begin
            unique case (ccls)
                RG_VDUM, RG_DUM, RG_DDUM: reg_c = ccls;
                RG_CTE:  reg_c = (lead_cte && cte_dark) ? RG_DDUM : RG_CTE;
                RG_DREF: reg_c = (lcls == LC_DDUM) ? RG_DDUM : RG_DREF;
                default: begin
                    unique case (lcls)
                        LC_DDUM: reg_c = RG_DDUM;
                        LC_DARK: reg_c = RG_DREF;
                        LC_BLUE: reg_c = RG_BLUE;
                        LC_ABUF: reg_c = (ccls == RG_BLUE) ? RG_BLUE : RG_ABUF;
                        default: reg_c = ccls;
                    endcase
                end
            endcase
        end
        if (MONO != 0 && reg_c == RG_BLUE) reg_c = RG_ABUF;
    end

    assign region  = reg_c;
    assign act_stb = pix_vld && (reg_c == RG_ACT);
    assign dark_ok = pix_vld && (reg_c == RG_DREF);

    pixreg_dark_avg #(
        .DATA_W    (DATA_W),
        .DARK_COLS (DARK_COLS)
    ) i_avg (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_en     (dark_ok && dref_span),
        .smp_first  (dref_first),
        .smp_last   (dref_last),
        .smp_data   (pix_data),
        .dark_level (dark_level),
        .dark_upd   (dark_upd)
    );

    // R7: image strobe only on image lines
    a_r7_act_on_image_line: assert property (@(posedge clk) disable iff (!rst_n)
        act_stb |-> (lcls == LC_ACT));

    // R8: dark flag only from the trailing band or a shielded line
    a_r8_dark_source: assert property (@(posedge clk) disable iff (!rst_n)
        dark_ok |-> (dref_span || lcls == LC_DARK));

    // R3: dark-dummy lines never yield dark reference
    a_r3_no_dref_on_ddum: assert property (@(posedge clk) disable iff (!rst_n)
        (lcls == LC_DDUM) |-> (region != 3'd7));

    // R12: out-of-map indices raise no strobe
    a_r12_out_of_map_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_in || lcls == LC_NONE) |-> (!act_stb && !dark_ok));

    // R11: monochrome build never reports a blue buffer
    a_r11_mono_no_blue: assert property (@(posedge clk) disable iff (!rst_n)
        (MONO != 0) |-> (region != 3'd4));

endmodule

// File: tb/test_pixreg_tagger.sv
`timescale 1ns/1ps
module test_pixreg_tagger;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pv = 1'b0;
    logic [11:0] ln_i = '0;
    logic [11:0] cl_i = '0;
    logic [11:0] dat_i = '0;

    logic [2:0]  reg_c, reg_m;
    logic        dok_c, dok_m, act_c, act_m, upd_c, upd_m;
    logic [11:0] lvl_c, lvl_m;

    int total = 0;
    int bad = 0;
    bit gap_mode = 1'b0;

    always #2.5 clk = ~clk;

    pixreg_tagger #(.MONO(0)) i_pixreg_tagger (
        .clk(clk), .rst_n(rst_n), .pix_vld(pv), .line_idx(ln_i), .col_idx(cl_i),
        .pix_data(dat_i), .region(reg_c), .dark_ok(dok_c), .act_stb(act_c),
        .dark_level(lvl_c), .dark_upd(upd_c)
    );

    pixreg_tagger #(.MONO(1)) i_pixreg_tagger_mono (
        .clk(clk), .rst_n(rst_n), .pix_vld(pv), .line_idx(ln_i), .col_idx(cl_i),
        .pix_data(dat_i), .region(reg_m), .dark_ok(dok_m), .act_stb(act_m),
        .dark_level(lvl_m), .dark_upd(upd_m)
    );

    // ---------------- reference model ----------------
    function automatic int col_cls(int c);
        if (c >= 1 && c <= 4)       return 0;
        if (c >= 5 && c <= 12)      return 1;
        if (c == 13)                return 2;
        if (c >= 14 && c <= 18)     return 1;
        if (c >= 19 && c <= 23)     return 3;
        if (c >= 24 && c <= 27)     return 4;
        if (c >= 28 && c <= 43)     return 5;
        if (c >= 44 && c <= 3369)   return 6;
        if (c >= 3370 && c <= 3385) return 5;
        if (c >= 3386 && c <= 3389) return 4;
        if (c >= 3390 && c <= 3397) return 3;
        if (c >= 3398 && c <= 3436) return 7;
        if (c >= 3437 && c <= 3442) return 3;
        if (c >= 3443 && c <= 3445) return 1;
        if (c == 3446)              return 2;
        if (c >= 3447 && c <= 3448) return 1;
        return -1;
    endfunction

    // 0 dark dummy, 1 shielded, 2 blue, 3 active buffer, 4 image
    function automatic int line_cls(int l);
        if ((l >= 1 && l <= 6) || (l >= 19 && l <= 26) || (l >= 2571 && l <= 2574)) return 0;
        if (l >= 7 && l <= 18) return 1;
        if ((l >= 27 && l <= 30) || (l >= 2551 && l <= 2554)) return 2;
        if ((l >= 31 && l <= 46) || (l >= 2555 && l <= 2570)) return 3;
        if (l >= 47 && l <= 2550) return 4;
        return -1;
    endfunction

    function automatic int exp_reg(int l, int c, bit m);
        int cc;
        int lc;
        int r;
        cc = col_cls(c);
        lc = line_cls(l);
        if (cc < 0 || lc < 0) return 1;
        if (cc == 0 || cc == 1 || cc == 3) r = cc;
        else if (cc == 2) r = (c == 13 && l > 1411) ? 3 : 2;
        else if (cc == 7) r = (lc == 0) ? 3 : 7;
        else begin
            case (lc)
                0: r = 3;
                1: r = 7;
                2: r = 4;
                3: r = (cc == 4) ? 4 : 5;
                default: r = cc;
            endcase
        end
        if (m && r == 4) r = 5;
        return r;
    endfunction

    function automatic string rtag(int l, int c, bit m);
        int lc;
        lc = line_cls(l);
        if (col_cls(c) < 0 || lc < 0) return "R12";
        if (c == 13) return "R6";
        if (m && exp_reg(l, c, 1'b0) == 4) return "R11";
        if (lc == 0) return "R3";
        if (lc == 1) return "R4";
        if (lc == 2 || lc == 3) return "R5";
        return "R1 R2";
    endfunction

    int exp_sum = 0;
    int exp_lvl = 0;
    bit exp_upd = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_sum = 0; exp_lvl = 0; exp_upd = 1'b0;
        end else begin
            exp_upd = 1'b0;
            if (pv && int'(cl_i) >= 3398 && int'(cl_i) <= 3436 &&
                exp_reg(int'(ln_i), int'(cl_i), 1'b0) == 7) begin
                if (int'(cl_i) == 3398) exp_sum = int'(dat_i);
                else                    exp_sum = exp_sum + int'(dat_i);
                if (int'(cl_i) == 3436) begin
                    exp_lvl = exp_sum / 39;
                    exp_upd = 1'b1;
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s line=%0d col=%0d actual=%0d expected=%0d",
                     tag, ln_i, cl_i, act, exp);
        end
    endtask

    task automatic check_dut(bit m, int r, bit a, bit d, int lv, bit u);
        int er;
        string lt;
        er = exp_reg(int'(ln_i), int'(cl_i), m);
        lt = gap_mode ? "R13" : "R10";
        check(r == er, rtag(int'(ln_i), int'(cl_i), m), r, er);
        check(a == (pv && er == 6), pv ? "R7" : "R13", int'(a), int'(pv && er == 6));
        check(d == (pv && er == 7), pv ? "R8" : "R13", int'(d), int'(pv && er == 7));
        check(lv == exp_lvl, lt, lv, exp_lvl);
        check(u == exp_upd, "R9", int'(u), int'(exp_upd));
    endtask

    always @(negedge clk) begin
        check_dut(1'b0, int'(reg_c), act_c, dok_c, int'(lvl_c), upd_c);
        check_dut(1'b1, int'(reg_m), act_m, dok_m, int'(lvl_m), upd_m);
    end

    // ---------------- stimulus ----------------
    task automatic drive(int l, int c, bit v, int d);
        @(posedge clk);
        #1;
        pv = v; ln_i = 12'(l); cl_i = 12'(c); dat_i = 12'(d);
    endtask

    task automatic run_line(int l, int pat, bit gaps);
        int d;
        gap_mode = gaps;
        drive(l, 0, 1'b1, 5);
        for (int c = 1; c <= 3449; c++) begin
            if (gaps && ($urandom % 6 == 0)) drive(l, c, 1'b0, int'($urandom % 4096));
            case (pat)
                1:       d = 4095;
                2:       d = c % 4096;
                3:       d = (c == 3398) ? 38 : 0;
                default: d = int'($urandom % 4096);
            endcase
            drive(l, c, 1'b1, d);
        end
        drive(l, 4095, 1'b1, 7);
        drive(l, 1, 1'b0, 0);
        drive(l, 1, 1'b0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        run_line(1, 0, 1'b0);      // R3 leading dark dummy
        run_line(7, 1, 1'b0);      // R4 shielded, max sum
        run_line(13, 3, 1'b0);     // R9 floor just under one
        run_line(19, 0, 1'b0);     // R3 middle dark dummy
        run_line(27, 0, 1'b0);     // R5 blue lines, R11
        run_line(40, 2, 1'b0);     // R5 active buffer lines
        run_line(47, 0, 1'b0);     // R1 first image line
        run_line(100, 1, 1'b0);    // R9 full-scale average
        run_line(1411, 2, 1'b0);   // R6 last test line
        run_line(1412, 0, 1'b1);   // R6 switch, R13 gaps
        run_line(7, 0, 1'b1);      // R13 gaps on shielded line
        run_line(2550, 0, 1'b0);   // R1 last image line
        run_line(2551, 0, 1'b0);   // R5 trailing blue
        run_line(2560, 0, 1'b0);   // R5 trailing active buffer
        run_line(2571, 0, 1'b0);   // R3 trailing dark dummy
        run_line(2575, 0, 1'b0);   // R12
        run_line(0, 0, 1'b0);      // R12
        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule